// File: doc/BRIEF.md
# Stop-Mode Power Sequencer

This block sequences a small microcontroller into and out of three stop depths. In run mode the CPU raises a one-cycle stop request together with a two-bit depth code. The block then shuts off the peripheral clocks. One cycle later it applies that depth's retention map to eight power domains. Each domain is driven as on, in standby, or off through a power-enable and a standby-enable bit.

While stopped, the block watches two wake sources. The first is an active-low wake pin, which passes through a synchronizer and a low-level qualifier. The second is a real-time interrupt event, which counts only when its enable input is set.

Waking from the medium or light depth reverses the entry order: domains come back first, then clocks, and a one-cycle done pulse marks the return to run. Waking from the deep depth is turned into a power-on-style reset. That reset is held for as long as the supply-below-trip input stays active. The deep wake also sets a sticky power-down flag that software clears with a write-1 acknowledge.

Top module: `pwr_stop_seq`

## Requirements
- R1: After reset the block is in run mode with the following outputs:
  - `periph_clk_en`=1
  - every `dom_pwr` bit 1 and every `dom_stby` bit 0
  - `pdf`=0
  - `por_rst`=0
  - `io_force_rst`=0
  - `wake_done`=0
- R2: When run mode samples `stop_req`=1 with a valid depth, `periph_clk_en` drops after that edge while all domains stay on. The depth map is applied after the following edge.
- R3: Domain bits are ordered as follows: 0 CPU, 1 RAM, 2 flash, 3 port registers, 4 ADC, 5 comparator, 6 clock generator, 7 I2C. Each state is encoded as on (pwr=1, stby=0), standby (pwr=1, stby=1) or off (pwr=0, stby=0). The maps per depth code are:
  - Depth 2'b01 (deep): all domains off.
  - Depth 2'b10 (medium): RAM in standby, the rest off.
  - Depth 2'b11 (light): ADC on if `adc_keep`=1, else off; clock generator on if `clkgen_keep`=1, else off; every other domain in standby.
- R4: `periph_clk_en` is 0 in every state except run, whatever `dbg_en` is. `dbg_clk_en` is 1 in run and otherwise equals `dbg_en`.
- R5: `io_force_rst` is 1 while stopped at the deep depth and during the reset hold after a deep wake.
- R6: The wake pin is synchronized through two flops. A wake is accepted once the synchronized level has been low on two consecutive cycles, and a single-cycle low pulse causes no wake. `wake_pull_en` always follows `wake_pull_cfg`.
- R7: A `rti_evt` pulse wakes the block only when `rti_en`=1.
- R8: On a medium or light wake, the first cycle has all domains on with clocks still gated. The next cycle has clocks on and `wake_done`=1 for exactly one cycle.
- R9: On a deep wake, `por_rst`=1 with all domains on and clocks gated. This holds while `lv_below`=1. The cycle after `lv_below` is seen at 0, the block returns to run with `wake_done`=1.
- R10: `pdf` is set by a deep wake, not by a medium or light wake. It stays set until `pdf_ack`=1 is sampled, and a set on the same edge wins.
- R11: A stop request with depth 2'b00 is ignored and the block stays in run. A stop request outside run mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| stop_req | input | 1 | Stop request pulse from the CPU |
| stop_depth | input | 2 | Depth code: 01 deep, 10 medium, 11 light, 00 reserved |
| adc_keep | input | 1 | Keep ADC powered in light stop |
| clkgen_keep | input | 1 | Keep clock generator powered in light stop |
| dbg_en | input | 1 | Keep debug clock running |
| wake_pin_n | input | 1 | Active-low asynchronous wake pin |
| wake_pull_cfg | input | 1 | Pull-up enable setting for the wake pin |
| rti_en | input | 1 | Real-time interrupt wake enable |
| rti_evt | input | 1 | Real-time interrupt event |
| lv_below | input | 1 | Supply below low trip point |
| pdf_ack | input | 1 | Write-1 acknowledge of the power-down flag |
| periph_clk_en | output | 1 | Peripheral clock enable |
| dbg_clk_en | output | 1 | Debug clock enable |
| dom_pwr | output | NDOM | Per-domain power enable |
| dom_stby | output | NDOM | Per-domain standby enable |
| io_force_rst | output | 1 | Force I/O pins to their reset state |
| por_rst | output | 1 | Power-on-style reset to core and modules |
| wake_pull_en | output | 1 | Wake pin pull-up enable |
| pdf | output | 1 | Sticky power-down flag |
| wake_done | output | 1 | One-cycle pulse on return to run |

## Verification
Every result has a fixed cycle count from its stimulus, and the bench samples exactly at that count:
- Clock gating is visible one edge after the request.
- The domain map is visible after a second edge.
- An interrupt wake changes the outputs one edge after the event is sampled.
- A pin wake takes effect on the fourth edge after the pin falls.
- The done pulse follows one edge after the restore cycle, or one edge after the low-voltage input clears.

Inputs change one time unit after a rising edge, and outputs are read at that same offset. Each check therefore sees the state settled by the previous edge. The bench sweeps every depth code, both keep inputs, both wake sources and the low-voltage hold, and it works out the expected domain vectors from the depth rules.

// File: rtl/pwr_stop_pkg.sv
package pwr_stop_pkg;

   typedef enum logic [1:0] {
      DEPTH_RSVD  = 2'b00,
      DEPTH_DEEP  = 2'b01,
      DEPTH_MED   = 2'b10,
      DEPTH_LIGHT = 2'b11
   } depth_e;

   typedef enum logic [2:0] {
      SEQ_RUN,
      SEQ_GATE,
      SEQ_STOP,
      SEQ_RESUME,
      SEQ_PORHOLD
   } seq_e;

   typedef enum logic [1:0] {
      DOM_ON,
      DOM_STBY,
      DOM_OFF
   } dom_e;

   localparam int NUM_DOM    = 8;
   localparam int DOM_CPU    = 0;
   localparam int DOM_RAM    = 1;
   localparam int DOM_FLASH  = 2;
   localparam int DOM_PORT   = 3;
   localparam int DOM_ADC    = 4;
   localparam int DOM_CMP    = 5;
   localparam int DOM_CLKGEN = 6;
   localparam int DOM_I2C    = 7;

   // Retention rule for one domain at one depth
   function automatic dom_e dom_rule(input depth_e d, input int idx,
                                     input logic adc_keep, input logic clk_keep);
      dom_e r;
      unique case (d)
         DEPTH_DEEP:  r = DOM_OFF;
         DEPTH_MED:   r = (idx == DOM_RAM) ? DOM_STBY : DOM_OFF;
         DEPTH_LIGHT: begin
            if (idx == DOM_ADC)         r = adc_keep ? DOM_ON : DOM_OFF;
            else if (idx == DOM_CLKGEN) r = clk_keep ? DOM_ON : DOM_OFF;
            else                        r = DOM_STBY;
         end
         default:     r = DOM_ON;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL        = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic wake_o
);
   localparam int CW = $clog2(QUAL + 1);
   localparam logic [CW-1:0] QMAX = CW'(QUAL);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwr_wake_filter: SYNC_STAGES must be at least 2");
   end
   if (QUAL < 1) begin : g_bad_qual
      $error("pwr_wake_filter: QUAL must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sq;
   logic [CW-1:0]          cnt;
   logic                   sync_low;

   assign sync_low = ~sq[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq  <= '1;
         cnt <= '0;
      end else begin
         sq <= {sq[SYNC_STAGES-2:0], pin_n};
         if (!sync_low)      cnt <= '0;
         else if (cnt != QMAX) cnt <= cnt + 1'b1;
      end
   end

   assign wake_o = sync_low && (cnt >= QMAX - 1'b1);

   // R6
   glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_o && QUAL >= 2) |-> $past(sync_low));

endmodule

// File: rtl/pwr_domain_map.sv
module pwr_domain_map
   import pwr_stop_pkg::*;
#(
   parameter int NDOM = NUM_DOM
) (
   input  logic            active_i,
   input  depth_e          depth_i,
   input  logic            adc_keep,
   input  logic            clk_keep,
   output logic [NDOM-1:0] pwr_o,
   output logic [NDOM-1:0] stby_o
);
   if (NDOM != NUM_DOM) begin : g_bad_ndom
      $error("pwr_domain_map: NDOM must match the domain list");
   end

   for (genvar i = 0; i < NDOM; i++) begin : g_dom
      dom_e s;
      assign s         = active_i ? dom_rule(depth_i, i, adc_keep, clk_keep) : DOM_ON;
      assign pwr_o[i]  = (s != DOM_OFF);
      assign stby_o[i] = (s == DOM_STBY);
   end

endmodule

// File: rtl/pwr_stop_fsm.sv
module pwr_stop_fsm
   import pwr_stop_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   stop_req,
   input  depth_e depth_i,
   input  logic   wake_i,
   input  logic   lv_below,
   input  logic   pdf_ack,
   output seq_e   state_o,
   output depth_e depth_o,
   output logic   pdf_o,
   output logic   done_o
);
   seq_e   state;
   depth_e depth_q;
   logic   pdf_q, done_q;
   logic   deep_wake;

   assign deep_wake = (state == SEQ_STOP) && wake_i && (depth_q == DEPTH_DEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_RUN;
         depth_q <= DEPTH_DEEP;
         pdf_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            SEQ_RUN: if (stop_req && depth_i != DEPTH_RSVD) begin
               depth_q <= depth_i;
               state   <= SEQ_GATE;
            end
            SEQ_GATE: state <= SEQ_STOP;
            SEQ_STOP: if (wake_i)
               state <= (depth_q == DEPTH_DEEP) ? SEQ_PORHOLD : SEQ_RESUME;
            SEQ_RESUME: begin
               state  <= SEQ_RUN;
               done_q <= 1'b1;
            end
            SEQ_PORHOLD: if (!lv_below) begin
               state  <= SEQ_RUN;
               done_q <= 1'b1;
            end
            default: state <= SEQ_RUN;
         endcase
         if (deep_wake)    pdf_q <= 1'b1;
         else if (pdf_ack) pdf_q <= 1'b0;
      end
   end

   assign state_o = state;
   assign depth_o = depth_q;
   assign pdf_o   = pdf_q;
   assign done_o  = done_q;

   // R9
   por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_PORHOLD && lv_below) |=> state == SEQ_PORHOLD);
   // R10
   pdf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pdf_q && !pdf_ack) |=> pdf_q);
   // R11
   rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_RUN && stop_req && depth_i == DEPTH_RSVD) |=> state == SEQ_RUN);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/pwr_stop_seq.sv
module pwr_stop_seq
   import pwr_stop_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WAKE_QUAL   = 2,
   parameter int NDOM        = NUM_DOM
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stop_req,
   input  logic [1:0]      stop_depth,
   input  logic            adc_keep,
   input  logic            clkgen_keep,
   input  logic            dbg_en,
   input  logic            wake_pin_n,
   input  logic            wake_pull_cfg,
   input  logic            rti_en,
   input  logic            rti_evt,
   input  logic            lv_below,
   input  logic            pdf_ack,
   output logic            periph_clk_en,
   output logic            dbg_clk_en,
   output logic [NDOM-1:0] dom_pwr,
   output logic [NDOM-1:0] dom_stby,
   output logic            io_force_rst,
   output logic            por_rst,
   output logic            wake_pull_en,
   output logic            pdf,
   output logic            wake_done
);
   seq_e   state;
   depth_e depth_q;
   logic   pin_wake, wake_any;

   pwr_wake_filter #(.SYNC_STAGES(SYNC_STAGES), .QUAL(WAKE_QUAL)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_n(wake_pin_n), .wake_o(pin_wake));

   assign wake_any = pin_wake || (rti_en && rti_evt);

   pwr_stop_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
      .depth_i(depth_e'(stop_depth)), .wake_i(wake_any),
      .lv_below(lv_below), .pdf_ack(pdf_ack),
      .state_o(state), .depth_o(depth_q), .pdf_o(pdf), .done_o(wake_done));

   pwr_domain_map #(.NDOM(NDOM)) u_map (
      .active_i(state == SEQ_STOP), .depth_i(depth_q),
      .adc_keep(adc_keep), .clk_keep(clkgen_keep),
      .pwr_o(dom_pwr), .stby_o(dom_stby));

   assign periph_clk_en = (state == SEQ_RUN);
   assign dbg_clk_en    = (state == SEQ_RUN) || dbg_en;
   assign io_force_rst  = ((state == SEQ_STOP) && depth_q == DEPTH_DEEP)
                        || (state == SEQ_PORHOLD);
   assign por_rst       = (state == SEQ_PORHOLD);
   assign wake_pull_en  = wake_pull_cfg;

   // R2
   gate_before_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(periph_clk_en) |-> &dom_pwr);
   // R8
   power_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_clk_en) |-> ($past(&dom_pwr) && !$past(|dom_stby)));
   // R9
   por_domains_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_rst |-> (&dom_pwr && !periph_clk_en));

endmodule

// File: tb/pwr_stop_seq_bench.sv
module pwr_stop_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_req = 0, adc_keep = 0, clkgen_keep = 0, dbg_en = 0;
   logic [1:0] stop_depth = 0;
   logic       wake_pin_n = 1, wake_pull_cfg = 0, rti_en = 0, rti_evt = 0;
   logic       lv_below = 0, pdf_ack = 0;
   logic       periph_clk_en, dbg_clk_en, io_force_rst, por_rst, wake_pull_en, pdf, wake_done;
   logic [7:0] dom_pwr, dom_stby;
   int total = 0, bad = 0;

   always #5 clk = ~clk;

   pwr_stop_seq u_pwr_stop_seq (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_depth(stop_depth),
      .adc_keep(adc_keep), .clkgen_keep(clkgen_keep), .dbg_en(dbg_en),
      .wake_pin_n(wake_pin_n), .wake_pull_cfg(wake_pull_cfg), .rti_en(rti_en),
      .rti_evt(rti_evt), .lv_below(lv_below), .pdf_ack(pdf_ack),
      .periph_clk_en(periph_clk_en), .dbg_clk_en(dbg_clk_en), .dom_pwr(dom_pwr),
      .dom_stby(dom_stby), .io_force_rst(io_force_rst), .por_rst(por_rst),
      .wake_pull_en(wake_pull_en), .pdf(pdf), .wake_done(wake_done));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // expected {pwr, stby} per depth code, computed from the rules
   function automatic logic [15:0] exp_map(input int d, input int adc, input int ck);
      logic [7:0] p, s;
      for (int i = 0; i < 8; i++) begin
         p[i] = 1'b1; s[i] = 1'b0;
         if (d == 1) p[i] = 1'b0;
         else if (d == 2) begin
            p[i] = (i == 1); s[i] = (i == 1);
         end else if (d == 3) begin
            if (i == 4)      p[i] = (adc != 0);
            else if (i == 6) p[i] = (ck != 0);
            else             s[i] = 1'b1;
         end
      end
      return {p, s};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] em;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 clk", periph_clk_en, 1);
      chk("R1 pwr", dom_pwr, 8'hff);
      chk("R1 stby", dom_stby, 0);
      chk("R1 pdf/por/io/done", {pdf, por_rst, io_force_rst, wake_done}, 0);

      for (int d = 0; d < 4; d++)
      for (int adc = 0; adc < 2; adc++)
      for (int ck = 0; ck < 2; ck++)
      for (int src = 0; src < 2; src++) begin
         adc_keep = adc[0]; clkgen_keep = ck[0]; dbg_en = adc[0] ^ ck[0];
         wake_pull_cfg = src[0];
         em = exp_map(d, adc, ck);
         stop_depth = d[1:0]; stop_req = 1;
         step();
         stop_req = 0;
         // R6 pull-up follows its setting
         chk("R6 pull", wake_pull_en, src[0]);
         if (d == 0) begin
            // R11 reserved depth ignored
            chk("R11 rsvd clk", periph_clk_en, 1);
            step();
            chk("R11 rsvd pwr", {periph_clk_en, dom_pwr}, 9'h1ff);
            continue;
         end
         // R2 clocks gated first, domains still on
         chk("R2 gate", {periph_clk_en, dom_pwr, dom_stby}, {1'b0, 8'hff, 8'h00});
         step();
         // R3 map applied
         chk("R3 map", {dom_pwr, dom_stby}, em);
         // R4 clocks stay off, debug clock follows dbg_en
         chk("R4 clk", {periph_clk_en, dbg_clk_en}, {1'b0, dbg_en});
         // R5 I/O forced only at deep depth
         chk("R5 io", io_force_rst, (d == 1));
         // R11 request while stopped ignored
         stop_depth = (d == 1) ? 2'b11 : 2'b01; stop_req = 1;
         step();
         stop_req = 0;
         chk("R11 busy req", {dom_pwr, dom_stby}, em);
         // R7 RTI without enable does nothing
         rti_en = 0; rti_evt = 1;
         step();
         rti_evt = 0;
         chk("R7 rti off", {periph_clk_en, dom_pwr, dom_stby}, {1'b0, em});
         if (d == 1) lv_below = src[0];
         if (src == 0) begin
            // R6 single-cycle glitch rejected
            wake_pin_n = 0; step(); wake_pin_n = 1;
            step(); step(); step();
            chk("R6 glitch", {dom_pwr, dom_stby}, em);
            wake_pin_n = 0;
            step(); step(); step();
            chk("R6 not yet", {dom_pwr, dom_stby}, em);
            step();
            wake_pin_n = 1;
         end else begin
            rti_en = 1; rti_evt = 1;
            step();
            rti_evt = 0; rti_en = 0;
         end
         if (d == 1) begin
            // R9 power-on style reset
            chk("R9 por", {por_rst, periph_clk_en, dom_pwr, dom_stby}, {1'b1, 1'b0, 8'hff, 8'h00});
            chk("R5 io hold", io_force_rst, 1);
            chk("R10 set", pdf, 1);
            if (src == 1) begin
               step();
               chk("R9 lv hold", {por_rst, wake_done}, 2'b10);
               lv_below = 0;
            end
            step();
            chk("R9 release", {por_rst, periph_clk_en, wake_done}, 3'b011);
            step();
            chk("R10 sticky", {pdf, wake_done}, 2'b10);
            pdf_ack = 1;
            step();
            pdf_ack = 0;
            chk("R10 ack", pdf, 0);
         end else begin
            // R8 domains first, then clocks
            chk("R8 restore", {periph_clk_en, dom_pwr, dom_stby, wake_done}, {1'b0, 8'hff, 8'h00, 1'b0});
            step();
            chk("R8 run", {periph_clk_en, wake_done}, 2'b11);
            step();
            chk("R8 pulse end", wake_done, 0);
            chk("R10 no set", pdf, 0);
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule